// File: doc/BRIEF.md
# IDE register window bridge

This block is the host-side front end of a disk controller channel. A 32-bit, little-endian host bus issues single accesses into a 4 KB window. The block works out a register slot from each address, with one slot for every 16 bytes. It checks that the access width is legal for that slot. Legal accesses to the drive registers go out on a simple ATA register port. Two registers live inside the block itself: a 32-bit timing register, which is only stored, and an interrupt state register. The interrupt state register shows the levels of the DMA and disk interrupt lines. Its DMA bit is latched and is cleared by writing a one to it.

A small state machine runs the host handshake. In ST_IDLE the block is ready, and a write completes in the cycle it is accepted. An accepted read moves the machine to ST_RESP (transition "read accepted"). The registered read data is presented in ST_RESP. The machine then returns to ST_IDLE (transition "response delivered"). Each interrupt input is also driven straight out on its own pin.

Top module: `ide_win_bridge`

## Requirements
- R1: The slot is address bits [11:4], so bits [3:0] do not change which slot is selected. A read of any slot other than 0x00, 0x01–0x07, 0x08, 0x16, 0x20 or 0x30 returns 0xFFFFFFFF. A write to such a slot is not forwarded and changes no register.
- R2: Slot 0x00 is the data port. It is forwarded with `ata_sel` = 0 only for size 2 or size 4 (sizes are encoded 1, 2 or 4 bytes). Any other size is not forwarded, and such a read returns 0xFFFFFFFF.
- R3: Slots 0x01–0x07 are forwarded with `ata_sel` equal to the slot number, for size 1 only. Any other size is not forwarded, and such a read returns 0xFFFFFFFF.
- R4: Slots 0x08 and 0x16 are both forwarded with `ata_sel` = 8. A read of either slot returns status and a write to either slot issues a command. Only size 1 is accepted.
- R5: Slot 0x20 is a timing register that accepts size 4 only. It reads back the last size-4 value written to it. It is 0 after reset, and accesses of any other size leave it unchanged.
- R6: Slot 0x30 is the interrupt state register and accepts size 4 only. Bit 31 is the DMA interrupt bit and bit 30 follows the disk interrupt input. All other bits read 0, and the register is 0 after reset.
- R7: The DMA bit is set when the DMA input rises and cleared when the DMA input falls. A size-4 write to slot 0x30 with bit 31 set also clears it. After such a clear, the bit stays 0 until the input rises again. Writes never change bit 30.
- R8: `irq_dma_out` and `irq_disk_out` follow `irq_dma_in` and `irq_disk_in` in the same cycle.
- R9: `h_ready` is high in ST_IDLE, and a write completes in the cycle it is accepted. An accepted read raises `h_rvalid` with its data in the next cycle, and `h_ready` is low during that cycle.
- R10: A forwarded read of size 1 returns `ata_rdata[7:0]` zero-extended. A forwarded read of size 2 returns `ata_rdata[15:0]` zero-extended. A forwarded read of size 4 returns all of `ata_rdata`. Writes drive `h_wdata` unchanged onto `ata_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Block can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 12 | Byte address inside the window |
| h_size | input | 3 | Access size in bytes (1, 2, 4) |
| h_wdata | input | 32 | Write data |
| h_rvalid | output | 1 | Read data valid |
| h_rdata | output | 32 | Read data |
| ata_req | output | 1 | Forwarded access strobe |
| ata_we | output | 1 | Forwarded access is a write |
| ata_sel | output | 4 | Drive register: 0 data, 1–7 task file, 8 status/command |
| ata_off | output | 4 | Byte offset inside the slot |
| ata_size | output | 3 | Forwarded access size |
| ata_wdata | output | 32 | Forwarded write data |
| ata_rdata | input | 32 | Drive register read data, valid while `ata_req` is high |
| irq_dma_in | input | 1 | DMA interrupt line |
| irq_disk_in | input | 1 | Disk interrupt line |
| irq_dma_out | output | 1 | DMA interrupt output |
| irq_disk_out | output | 1 | Disk interrupt output |

## Verification
The hardest case to reach is a cleared DMA bit while the DMA line is still high. Seen from the ports, the bit has to stay 0 until the line goes low and rises again. The bench raises the DMA line, writes bit 31, and then reads repeatedly while the line is held high. Only after that does it toggle the line. The random phase runs with both interrupt lines high, so random writes to slot 0x30 can clear the DMA bit while the disk bit must survive. The random addresses mix the mapped slots with unmapped ones, use random low nibbles, and cover all sizes from 0 to 4.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ATA,
        TGT_TIMING,
        TGT_IRQ
    } tgt_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RESP
    } st_e;

    localparam logic [2:0] SZ_BYTE = 3'd1;
    localparam logic [2:0] SZ_HALF = 3'd2;
    localparam logic [2:0] SZ_WORD = 3'd4;

    localparam int SLOT_DATA    = 'h00;
    localparam int SLOT_TF_LAST = 'h07;
    localparam int SLOT_STAT_A  = 'h08;
    localparam int SLOT_STAT_B  = 'h16;
    localparam int SLOT_TIMING  = 'h20;
    localparam int SLOT_IRQ     = 'h30;

    localparam logic [3:0] SEL_DATA   = 4'd0;
    localparam logic [3:0] SEL_STATUS = 4'd8;

    typedef struct packed {
        tgt_e       tgt;
        logic [3:0] sel;
    } dec_t;

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
    import ide_win_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SLOT_SHIFT = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output dec_t              dec
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [SLOT_W-1:0] slot;
    assign slot = addr[ADDR_W-1:SLOT_SHIFT];

    always_comb begin
        dec.tgt = TGT_NONE;
        dec.sel = SEL_DATA;
        if (slot == SLOT_W'(SLOT_DATA)) begin
            if (size == SZ_HALF || size == SZ_WORD) begin
                dec.tgt = TGT_ATA;
                dec.sel = SEL_DATA;
            end
        end else if (slot <= SLOT_W'(SLOT_TF_LAST)) begin
            if (size == SZ_BYTE) begin
                dec.tgt = TGT_ATA;
                dec.sel = slot[3:0];
            end
        end else if (slot == SLOT_W'(SLOT_STAT_A) || slot == SLOT_W'(SLOT_STAT_B)) begin
            if (size == SZ_BYTE) begin
                dec.tgt = TGT_ATA;
                dec.sel = SEL_STATUS;
            end
        end else if (slot == SLOT_W'(SLOT_TIMING)) begin
            if (size == SZ_WORD) dec.tgt = TGT_TIMING;
        end else if (slot == SLOT_W'(SLOT_IRQ)) begin
            if (size == SZ_WORD) dec.tgt = TGT_IRQ;
        end
    end

    // a_r2_data_size / a_r3_tf_byte: a drive target is never granted a wrong width
    always_comb begin
        if (dec.tgt == TGT_ATA && dec.sel == SEL_DATA)
            a_r2_data_size: assert (size == SZ_HALF || size == SZ_WORD);
        if (dec.tgt == TGT_ATA && dec.sel != SEL_DATA)
            a_r3_tf_byte: assert (size == SZ_BYTE);
    end

endmodule

// File: rtl/ide_win_regs.sv
module ide_win_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tim_we,
    input  logic              irq_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_dma_in,
    input  logic              irq_disk_in,
    output logic [DATA_W-1:0] timing_q,
    output logic [DATA_W-1:0] irq_q
);
    localparam int DMA_BIT  = DATA_W - 1;
    localparam int DISK_BIT = DATA_W - 2;

    logic prev_dma;
    logic dma_bit;
    logic disk_bit;
    logic dma_rise;
    logic dma_fall;

    assign dma_rise = irq_dma_in & ~prev_dma;
    assign dma_fall = ~irq_dma_in & prev_dma;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_dma <= 1'b0;
            dma_bit  <= 1'b0;
            disk_bit <= 1'b0;
            timing_q <= '0;
        end else begin
            prev_dma <= irq_dma_in;
            disk_bit <= irq_disk_in;
            if (dma_rise)
                dma_bit <= 1'b1;
            else if (dma_fall)
                dma_bit <= 1'b0;
            else if (irq_we && wdata[DMA_BIT])
                dma_bit <= 1'b0;
            if (tim_we)
                timing_q <= wdata;
        end
    end

    always_comb begin
        irq_q           = '0;
        irq_q[DMA_BIT]  = dma_bit;
        irq_q[DISK_BIT] = disk_bit;
    end

    // R7: a one in bit 31 clears the DMA bit unless the line rises in the same cycle
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_we && wdata[DMA_BIT] && !dma_rise) |=> !irq_q[DMA_BIT]);

    // R7: with the line steady high, a cleared DMA bit stays cleared
    a_r7_no_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q[DMA_BIT] && prev_dma && irq_dma_in) |=> !irq_q[DMA_BIT]);

    // R5: the timing register moves only on its own write
    a_r5_timing_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tim_we |=> $stable(timing_q));

endmodule

// File: rtl/ide_win_bridge.sv
module ide_win_bridge
    import ide_win_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int SLOT_SHIFT = 4,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic              h_write,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [2:0]        h_size,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_rvalid,
    output logic [DATA_W-1:0] h_rdata,
    output logic              ata_req,
    output logic              ata_we,
    output logic [3:0]        ata_sel,
    output logic [SLOT_SHIFT-1:0] ata_off,
    output logic [2:0]        ata_size,
    output logic [DATA_W-1:0] ata_wdata,
    input  logic [DATA_W-1:0] ata_rdata,
    input  logic              irq_dma_in,
    input  logic              irq_disk_in,
    output logic              irq_dma_out,
    output logic              irq_disk_out
);
    st_e               state_q, state_d;
    dec_t              dec;
    logic              accept;
    logic              tim_we, irq_we;
    logic [DATA_W-1:0] timing_q, irq_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    ide_win_decode #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT)) u_dec (
        .addr (h_addr),
        .size (h_size),
        .dec  (dec)
    );

    assign accept = h_valid & h_ready;
    assign tim_we = accept & h_write & (dec.tgt == TGT_TIMING);
    assign irq_we = accept & h_write & (dec.tgt == TGT_IRQ);

    ide_win_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .tim_we      (tim_we),
        .irq_we      (irq_we),
        .wdata       (h_wdata),
        .irq_dma_in  (irq_dma_in),
        .irq_disk_in (irq_disk_in),
        .timing_q    (timing_q),
        .irq_q       (irq_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && !h_write)
                rdata_q <= rdata_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !h_write) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        h_ready  = (state_q == ST_IDLE);
        h_rvalid = (state_q == ST_RESP);
        h_rdata  = rdata_q;
    end

    assign ata_req   = accept & (dec.tgt == TGT_ATA);
    assign ata_we    = h_write;
    assign ata_sel   = dec.sel;
    assign ata_off   = h_addr[SLOT_SHIFT-1:0];
    assign ata_size  = h_size;
    assign ata_wdata = h_wdata;

    always_comb begin
        rdata_d = '1;
        unique case (dec.tgt)
            TGT_NONE:   rdata_d = '1;
            TGT_ATA: begin
                if (h_size == SZ_BYTE)
                    rdata_d = DATA_W'(ata_rdata[7:0]);
                else if (h_size == SZ_HALF)
                    rdata_d = DATA_W'(ata_rdata[15:0]);
                else
                    rdata_d = ata_rdata;
            end
            TGT_TIMING: rdata_d = timing_q;
            TGT_IRQ:    rdata_d = irq_q;
        endcase
    end

    assign irq_dma_out  = irq_dma_in;
    assign irq_disk_out = irq_disk_in;

    // R9: an accepted read is answered in the next cycle while the port is busy
    a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && h_ready && !h_write) |=> (h_rvalid && !h_ready));

    // R9: a response lasts one cycle and the port is ready again afterwards
    a_r9_back_ready: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |=> (h_ready && !h_rvalid));

    // R4: the status/command selector comes only from its two slots
    a_r4_status_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_req && ata_sel == SEL_STATUS) |->
        (h_addr[ADDR_W-1:SLOT_SHIFT] == (ADDR_W-SLOT_SHIFT)'(SLOT_STAT_A) ||
         h_addr[ADDR_W-1:SLOT_SHIFT] == (ADDR_W-SLOT_SHIFT)'(SLOT_STAT_B)));

    // R1: nothing is forwarded while a response is pending
    a_r1_no_fwd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> !ata_req);

endmodule

// File: tb/tb_ide_win_bridge.sv
module tb_ide_win_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_valid = 1'b0, h_write = 1'b0;
    logic [11:0] h_addr = '0;
    logic [2:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready, h_rvalid;
    logic [31:0] h_rdata;
    logic        ata_req, ata_we;
    logic [3:0]  ata_sel, ata_off;
    logic [2:0]  ata_size;
    logic [31:0] ata_wdata, ata_rdata;
    logic        irq_dma_in = 1'b0, irq_disk_in = 1'b0;
    logic        irq_dma_out, irq_disk_out;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] tim_sh = '0;
    logic [31:0] irq_sh = '0;

    always #4 clk = ~clk;

    ide_win_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
        .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata),
        .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .ata_req(ata_req), .ata_we(ata_we), .ata_sel(ata_sel),
        .ata_off(ata_off), .ata_size(ata_size), .ata_wdata(ata_wdata),
        .ata_rdata(ata_rdata),
        .irq_dma_in(irq_dma_in), .irq_disk_in(irq_disk_in),
        .irq_dma_out(irq_dma_out), .irq_disk_out(irq_disk_out)
    );

    function automatic logic [31:0] pat(input logic [3:0] s);
        return {8'h5A ^ {4'h0, s}, 8'hC0 + {4'h0, s}, 8'h30 + {4'h0, s}, 8'h80 + {4'h0, s}};
    endfunction

    always_comb ata_rdata = pat(ata_sel);

    function automatic bit legal(input int slot, input int sz);
        if (slot == 0) return (sz == 2 || sz == 4);
        if (slot <= 7 || slot == 'h08 || slot == 'h16) return (sz == 1);
        if (slot == 'h20 || slot == 'h30) return (sz == 4);
        return 0;
    endfunction

    function automatic bit fwd(input int slot, input int sz);
        return legal(slot, sz) && (slot <= 8 || slot == 'h16);
    endfunction

    function automatic logic [3:0] exp_sel(input int slot);
        if (slot <= 7) return 4'(slot);
        return 4'd8;
    endfunction

    function automatic logic [31:0] exp_rd(input int slot, input int sz);
        if (!legal(slot, sz)) return 32'hFFFF_FFFF;
        if (slot == 'h20) return tim_sh;
        if (slot == 'h30) return irq_sh;
        if (sz == 1) return {24'h0, pat(exp_sel(slot))[7:0]};
        if (sz == 2) return {16'h0, pat(exp_sel(slot))[15:0]};
        return pat(exp_sel(slot));
    endfunction

    function automatic string tag_of(input int slot);
        if (slot == 0) return "R2";
        if (slot <= 7) return "R3";
        if (slot == 'h08 || slot == 'h16) return "R4";
        if (slot == 'h20) return "R5";
        if (slot == 'h30) return "R7";
        return "R1";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one host access with forwarding, handshake and read data checks
    task automatic access(input bit w, input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, input string req);
        int slot = int'(a[11:4]);
        bit f = fwd(slot, int'(sz));
        logic [31:0] er;
        @(negedge clk);
        er = exp_rd(slot, int'(sz));
        h_valid = 1'b1; h_write = w; h_addr = a; h_size = sz; h_wdata = wd;
        #1;
        chk(req, {31'h0, ata_req}, {31'h0, f});
        if (f) begin
            chk(req, {28'h0, ata_sel}, {28'h0, exp_sel(slot)});
            chk(req, {31'h0, ata_we}, {31'h0, w});
            if (w) chk("R10", ata_wdata, wd);
        end
        @(negedge clk);
        h_valid = 1'b0;
        if (!w) begin
            chk("R9", {30'h0, h_rvalid, h_ready}, 32'h2);
            chk(req, h_rdata, er);
        end else begin
            chk("R9", {30'h0, h_rvalid, h_ready}, 32'h1);
            if (legal(slot, int'(sz)) && slot == 'h20) tim_sh = wd;
            if (legal(slot, int'(sz)) && slot == 'h30 && wd[31]) irq_sh[31] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk("R9", {30'h0, h_rvalid, h_ready}, 32'h1);
        chk("R8", {30'h0, irq_dma_out, irq_disk_out}, 32'h0);
        access(0, 12'h200, 3'd4, 0, "R5");
        access(0, 12'h300, 3'd4, 0, "R6");

        // R1: unmapped slots and ignored low nibble
        access(0, 12'h090, 3'd1, 0, "R1");
        access(0, 12'hFF0, 3'd4, 0, "R1");
        access(1, 12'h400, 3'd4, 32'h1234_5678, "R1");
        access(0, 12'h16C, 3'd1, 0, "R1");
        access(0, 12'h205, 3'd4, 0, "R1");

        // R2 / R10: data port widths
        access(0, 12'h000, 3'd2, 0, "R10");
        access(0, 12'h000, 3'd4, 0, "R2");
        access(0, 12'h000, 3'd1, 0, "R2");
        access(1, 12'h000, 3'd1, 32'hAA, "R2");
        access(1, 12'h002, 3'd4, 32'hCAFE_F00D, "R2");

        // R3 / R4: task file and status/command
        access(0, 12'h010, 3'd1, 0, "R3");
        access(0, 12'h070, 3'd1, 0, "R3");
        access(0, 12'h030, 3'd2, 0, "R3");
        access(1, 12'h050, 3'd1, 32'h3C, "R3");
        access(0, 12'h080, 3'd1, 0, "R4");
        access(1, 12'h160, 3'd1, 32'hEC, "R4");
        access(0, 12'h160, 3'd4, 0, "R4");

        // R5: timing register
        access(1, 12'h200, 3'd4, 32'hDEAD_BEEF, "R5");
        access(0, 12'h200, 3'd4, 0, "R5");
        access(1, 12'h200, 3'd2, 32'h0000_1111, "R5");
        access(0, 12'h200, 3'd4, 0, "R5");

        // R6 / R7 / R8: interrupt state
        @(negedge clk); irq_dma_in = 1'b1; #1;
        chk("R8", {31'h0, irq_dma_out}, 32'h1);
        irq_sh = 32'h8000_0000;
        access(0, 12'h300, 3'd4, 0, "R6");
        access(1, 12'h300, 3'd4, 32'h7FFF_FFFF, "R7");
        access(0, 12'h300, 3'd4, 0, "R7");
        access(1, 12'h300, 3'd4, 32'h8000_0000, "R7");
        access(0, 12'h300, 3'd4, 0, "R7");
        access(0, 12'h300, 3'd4, 0, "R7");
        @(negedge clk); irq_dma_in = 1'b0;
        @(negedge clk); irq_dma_in = 1'b1;
        irq_sh = 32'h8000_0000;
        access(0, 12'h300, 3'd4, 0, "R7");
        @(negedge clk); irq_dma_in = 1'b0;
        irq_sh = 32'h0;
        access(0, 12'h300, 3'd4, 0, "R7");
        @(negedge clk); irq_disk_in = 1'b1; #1;
        chk("R8", {31'h0, irq_disk_out}, 32'h1);
        irq_sh = 32'h4000_0000;
        access(1, 12'h300, 3'd4, 32'hFFFF_FFFF, "R7");
        access(0, 12'h300, 3'd4, 0, "R6");
        @(negedge clk); irq_disk_in = 1'b0;
        irq_sh = 32'h0;
        access(0, 12'h300, 3'd4, 0, "R6");

        // random phase with both lines high
        @(negedge clk); irq_dma_in = 1'b1; irq_disk_in = 1'b1;
        irq_sh = 32'hC000_0000;
        for (int i = 0; i < 400; i++) begin
            int pick = int'($urandom_range(0, 12));
            int slot;
            logic [11:0] a;
            case (pick)
                0:  slot = 0;
                1, 2, 3: slot = int'($urandom_range(1, 7));
                4:  slot = 'h08;
                5:  slot = 'h16;
                6, 7: slot = 'h20;
                8, 9: slot = 'h30;
                default: slot = int'($urandom_range(0, 255));
            endcase
            a = {slot[7:0], 4'($urandom_range(0, 15))};
            access(1'($urandom_range(0, 1)), a, 3'($urandom_range(0, 4)),
                   $urandom(), tag_of(slot));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule